// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every processor bus cycle and raises a break request when a cycle meets a programmed condition. It has two independent channels, A and B. Each channel compares a masked 32-bit address, taken from either the virtual or the internal address bus, and checks the cycle's bus master, cycle kind, direction and operand size. Channel B also compares a masked 32-bit data value, taken from either the virtual or the internal data bus. It can also hold back its break until its condition has occurred a programmed number of times.

Software programs the channels through a plain register write port. A matching cycle gives a one-cycle `brk_req` pulse on the next clock. The same edge sets a sticky per-channel hit flag, and sets `brk_post` when the break belongs after the fetched instruction rather than before it. The bus observation port has no back-pressure. `bus_valid` marks a cycle that is already committed, and the block samples it on every clock without stalling the bus.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, `brk_req`, `brk_post`, `hit_a` and `hit_b` are 0. Every control register resets to 0, so both channels are disabled. Address masks reset to 0, channel B's data mask resets to all ones and its repeat count resets to 0.
- R2: An address matches when, for every bit whose address-mask bit is 0, the bus address equals the compare value. Bits whose mask bit is 1 are excluded from the compare.
- R3: Control bit 8 picks the address source: 0 means `bus_vaddr`, 1 means `bus_iaddr`.
- R4: Control bits [1:0] select the cycle kind: 0 means the channel is disabled and never matches, 1 means instruction fetch only (`bus_fetch`=1), 2 means data access only, 3 means either.
- R5: Control bits [3:2] select the direction: 1 means read only (`bus_write`=0), 2 means write only, 0 or 3 means either.
- R6: Control bits [5:4] select the bus master: 1 means CPU only (`bus_dma`=0), 2 means DMA only, 0 or 3 means either.
- R7: Control bits [7:6] select the size: 0 means any size, and 1, 2 or 3 match `bus_size` equal to 0 (byte), 1 (word) or 2 (longword) respectively.
- R8: Channel B also requires a data match. Every data bit whose data-mask bit is 0 must equal the compare value. Control bit 9 picks the data source: 0 means `bus_vdata`, 1 means `bus_idata`.
- R9: Writing channel B's count register (offset 13) loads a 12-bit repeat counter. Each matching cycle while the counter is nonzero decrements it, and only the match that takes it from 1 to 0 fires. While the counter is 0, every match fires. A match in the same cycle as a count write neither counts nor fires.
- R10: `brk_req` is high for exactly the one clock after each cycle in which either channel matches.
- R11: A match sets its channel's sticky flag (`hit_a`, `hit_b`). Writing the status register (offset 15) with bit 0 (A) or bit 1 (B) equal to 0 clears that flag. A 1 in that bit leaves it unchanged. A new match wins over a clear in the same cycle.
- R12: `brk_post` goes high with `brk_req` only when a matching channel has control bit 10 set and the matching cycle is a fetch. Otherwise the break is signalled before execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset (A: 0 addr, 1 mask, 2 ctrl; B: 8 addr, 9 mask, 10 ctrl, 11 data, 12 data mask, 13 count; 15 status) |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_vaddr | input | 32 | Virtual address bus |
| bus_iaddr | input | 32 | Internal address bus |
| bus_vdata | input | 32 | Virtual data bus |
| bus_idata | input | 32 | Internal data bus |
| bus_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_dma | input | 1 | 1 for DMA-controller cycle, 0 for CPU cycle |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| brk_req | output | 1 | One-cycle break request |
| brk_post | output | 1 | Break is to be taken after the fetched instruction |
| hit_a | output | 1 | Sticky channel A match flag |
| hit_b | output | 1 | Sticky channel B match flag |

## Verification
The hardest condition to reach is channel B's repeat counter crossing from 1 to 0 while the data mask, data source and qualifiers also agree. A miss there looks the same at the ports as a channel that is not armed. The bench first sets B's address and data to pass in isolation. It then loads small counts, issues a counted run of matching cycles and expects exactly one pulse on the last one. After that it expects a pulse on every further match. The qualifier encodings are swept exhaustively on channel A against every combination of bus attributes.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef struct packed {
    logic       post;    // [10] fetch break after execution
    logic       dsel;    // [9]  data source: 0 virtual, 1 internal
    logic       asel;    // [8]  address source: 0 virtual, 1 internal
    logic [1:0] size;    // [7:6]
    logic [1:0] master;  // [5:4]
    logic [1:0] dir;     // [3:2]
    logic [1:0] kind;    // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] KIND_OFF   = 2'd0;
  localparam logic [1:0] KIND_FETCH = 2'd1;
  localparam logic [1:0] KIND_DATA  = 2'd2;

  localparam logic [3:0] OFF_ADDR  = 4'd0;
  localparam logic [3:0] OFF_MASK  = 4'd1;
  localparam logic [3:0] OFF_CTRL  = 4'd2;
  localparam logic [3:0] OFF_DATA  = 4'd3;
  localparam logic [3:0] OFF_DMASK = 4'd4;
  localparam logic [3:0] OFF_COUNT = 4'd5;

  localparam logic [3:0] BASE_A    = 4'd0;
  localparam logic [3:0] BASE_B    = 4'd8;
  localparam logic [3:0] REG_STAT  = 4'd15;
endpackage

// File: rtl/bbc_qual.sv
module bbc_qual
  import bbc_pkg::*;
(
  input  ctrl_t      ctl,
  input  logic       fetch,
  input  logic       write,
  input  logic       dma,
  input  logic [1:0] size,
  output logic       ok
);
  logic kind_ok, dir_ok, mst_ok, size_ok;

  always_comb begin
    unique case (ctl.kind)
      KIND_OFF:   kind_ok = 1'b0;
      KIND_FETCH: kind_ok = fetch;
      KIND_DATA:  kind_ok = !fetch;
      default:    kind_ok = 1'b1;
    endcase
    unique case (ctl.dir)
      2'd1:    dir_ok = !write;
      2'd2:    dir_ok = write;
      default: dir_ok = 1'b1;
    endcase
    unique case (ctl.master)
      2'd1:    mst_ok = !dma;
      2'd2:    mst_ok = dma;
      default: mst_ok = 1'b1;
    endcase
    if (ctl.size == 2'd0) size_ok = 1'b1;
    else                  size_ok = (size == ctl.size - 2'd1);
    ok = kind_ok && dir_ok && mst_ok && size_ok;
  end
endmodule

// File: rtl/bbc_chan.sv
module bbc_chan
  import bbc_pkg::*;
#(
  parameter int         AW       = 32,
  parameter int         DW       = 32,
  parameter int         CW       = 12,
  parameter bit         HAS_DATA = 1'b0,
  parameter logic [3:0] BASE     = 4'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_vaddr,
  input  logic [AW-1:0] bus_iaddr,
  input  logic [DW-1:0] bus_vdata,
  input  logic [DW-1:0] bus_idata,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic          bus_dma,
  input  logic [1:0]    bus_size,
  output logic          fire,
  output logic          post
);
  localparam logic [3:0] A_ADDR = BASE + OFF_ADDR;
  localparam logic [3:0] A_MASK = BASE + OFF_MASK;
  localparam logic [3:0] A_CTRL = BASE + OFF_CTRL;

  logic [AW-1:0] cmp_addr, cmp_mask;
  ctrl_t         ctl;
  logic          q_ok, a_ok, d_ok, c_ok, raw;
  logic [AW-1:0] sel_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_addr <= '0;
      cmp_mask <= '0;
      ctl      <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_ADDR) cmp_addr <= cfg_wdata;
      if (cfg_addr == A_MASK) cmp_mask <= cfg_wdata;
      if (cfg_addr == A_CTRL) ctl      <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end

  bbc_qual u_qual (
    .ctl   (ctl),
    .fetch (bus_fetch),
    .write (bus_write),
    .dma   (bus_dma),
    .size  (bus_size),
    .ok    (q_ok)
  );

  assign sel_addr = ctl.asel ? bus_iaddr : bus_vaddr;
  assign a_ok     = ((sel_addr ^ cmp_addr) & ~cmp_mask) == '0;
  assign raw      = bus_valid && q_ok && a_ok && d_ok;
  assign fire     = raw && c_ok;
  assign post     = ctl.post && bus_fetch;

  generate
    if (HAS_DATA) begin : g_data
      localparam logic [3:0] A_DATA  = BASE + OFF_DATA;
      localparam logic [3:0] A_DMASK = BASE + OFF_DMASK;
      localparam logic [3:0] A_COUNT = BASE + OFF_COUNT;
      logic [DW-1:0] cmp_data, cmp_dmask, sel_data;
      logic [CW-1:0] cnt;
      logic          cnt_wr;

      assign cnt_wr = cfg_we && (cfg_addr == A_COUNT);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cmp_data  <= '0;
          cmp_dmask <= '1;
        end else if (cfg_we) begin
          if (cfg_addr == A_DATA)  cmp_data  <= cfg_wdata[DW-1:0];
          if (cfg_addr == A_DMASK) cmp_dmask <= cfg_wdata[DW-1:0];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (cnt_wr)             cnt <= cfg_wdata[CW-1:0];
        else if (raw && cnt != '0)   cnt <= cnt - 1'b1;
      end

      assign sel_data = ctl.dsel ? bus_idata : bus_vdata;
      assign d_ok     = ((sel_data ^ cmp_data) & ~cmp_dmask) == '0;
      assign c_ok     = !cnt_wr && (cnt <= CW'(1));

      AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !cnt_wr) |=> (cnt == '0)) else $error("counter wrapped"); // R9
      AST_CNT_FIRE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cnt_wr) |=> (cnt == '0)) else $error("fire before count end"); // R9
    end else begin : g_nodata
      logic unused_bus;
      assign unused_bus = ^{bus_vdata, bus_idata, ctl.dsel};
      assign d_ok = 1'b1;
      assign c_ok = 1'b1;
    end
  endgenerate

  AST_OFF_NEVER_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.kind == KIND_OFF) |-> !fire) else $error("disabled channel fired"); // R4
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          bus_valid,
  input  logic [31:0]   bus_vaddr,
  input  logic [31:0]   bus_iaddr,
  input  logic [31:0]   bus_vdata,
  input  logic [31:0]   bus_idata,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic          bus_dma,
  input  logic [1:0]    bus_size,
  output logic          brk_req,
  output logic          brk_post,
  output logic          hit_a,
  output logic          hit_b
);
  localparam int NCH = 2;
  localparam logic [3:0] BASES [NCH] = '{BASE_A, BASE_B};

  logic [NCH-1:0] fire, post, flag;
  logic           stat_wr;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      bbc_chan #(
        .AW(AW), .DW(DW), .CW(CW),
        .HAS_DATA(c == 1), .BASE(BASES[c])
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata[AW-1:0]),
        .bus_valid (bus_valid),
        .bus_vaddr (bus_vaddr[AW-1:0]),
        .bus_iaddr (bus_iaddr[AW-1:0]),
        .bus_vdata (bus_vdata[DW-1:0]),
        .bus_idata (bus_idata[DW-1:0]),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .bus_dma   (bus_dma),
        .bus_size  (bus_size),
        .fire      (fire[c]),
        .post      (post[c])
      );

      always_ff @(posedge clk) begin
        if (!rst_n)       flag[c] <= 1'b0;
        else if (fire[c]) flag[c] <= 1'b1;
        else if (stat_wr && !cfg_wdata[c]) flag[c] <= 1'b0;
      end
    end
  endgenerate

  assign stat_wr = cfg_we && (cfg_addr == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_post <= 1'b0;
    end else begin
      brk_req  <= |fire;
      brk_post <= |(fire & post);
    end
  end

  assign hit_a = flag[0];
  assign hit_b = flag[1];

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid)) else $error("request without bus cycle"); // R10
  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (hit_a || hit_b)) else $error("request without flag"); // R11
  AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hit_a) |-> $past(stat_wr && !cfg_wdata[0])) else $error("flag A lost"); // R11
  AST_POST_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    brk_post |-> brk_req) else $error("post without request"); // R12
endmodule

// File: tb/bus_break_unit_test.sv
`timescale 1ns/1ps
module bus_break_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_vaddr = '0, bus_iaddr = '0, bus_vdata = '0, bus_idata = '0;
  logic        bus_fetch = 1'b0, bus_write = 1'b0, bus_dma = 1'b0;
  logic [1:0]  bus_size = '0;
  logic        brk_req, brk_post, hit_a, hit_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_break_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_vaddr(bus_vaddr),
    .bus_iaddr(bus_iaddr), .bus_vdata(bus_vdata), .bus_idata(bus_idata),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_dma(bus_dma),
    .bus_size(bus_size), .brk_req(brk_req), .brk_post(brk_post),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one bus cycle; on return brk_req reflects it
  task automatic cyc(input bit f, input bit w, input bit dm, input logic [1:0] sz);
    @(negedge clk);
    bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_dma = dm; bus_size = sz;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic bit qref(input logic [10:0] c, input bit f, input bit w,
                              input bit dm, input logic [1:0] sz);
    bit k, d, m, s;
    k = (c[1:0] == 2'd3) || (c[1:0] == 2'd1 && f) || (c[1:0] == 2'd2 && !f);
    d = (c[3:2] == 2'd1) ? !w : (c[3:2] == 2'd2) ? w : 1'b1;
    m = (c[5:4] == 2'd1) ? !dm : (c[5:4] == 2'd2) ? dm : 1'b1;
    s = (c[7:6] == 2'd0) || (sz == c[7:6] - 2'd1);
    return k && d && m && s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 brk_req", brk_req, 0);
    check("R1 brk_post", brk_post, 0);
    check("R1 hit_a", hit_a, 0);
    check("R1 hit_b", hit_b, 0);
    cyc(1, 0, 0, 2);
    check("R1 disabled after reset", brk_req, 0);

    // qualifier sweep on channel A (addr 0, mask 0 matches address 0)
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 4; d++)
        for (int m = 0; m < 4; m++)
          for (int s = 0; s < 4; s++) begin
            logic [10:0] c;
            c = {3'b000, 2'(s), 2'(m), 2'(d), 2'(k)};
            wr(4'd2, {21'd0, c});
            for (int f = 0; f < 2; f++)
              for (int w = 0; w < 2; w++)
                for (int dm = 0; dm < 2; dm++)
                  for (int sz = 0; sz < 3; sz++) begin
                    bit e;
                    e = qref(c, f[0], w[0], dm[0], 2'(sz));
                    cyc(f[0], w[0], dm[0], 2'(sz));
                    check("R4/R5/R6/R7 qualifier brk_req", brk_req, e);
                    check("R11 hit_a set", hit_a, e);
                    if (e) wr(4'd15, 32'h0);
                  end
          end

    // R10 pulse width
    wr(4'd2, 32'h3);
    cyc(0, 0, 0, 0);
    check("R10 pulse high", brk_req, 1);
    @(negedge clk);
    check("R10 pulse one cycle", brk_req, 0);

    // R11 write one keeps, write zero clears
    wr(4'd15, 32'h3);
    check("R11 write one keeps", hit_a, 1);
    wr(4'd15, 32'h2);
    check("R11 write zero clears", hit_a, 0);

    // R2 address mask, R3 bus select
    wr(4'd0, 32'h1234_5678);
    wr(4'd1, 32'h0000_00FF);
    bus_vaddr = 32'h1234_56AB; bus_iaddr = 32'h0;
    cyc(0, 0, 0, 0);
    check("R2 masked bits ignored", brk_req, 1);
    for (int b = 8; b < 32; b++) begin
      bus_vaddr = 32'h1234_5600 ^ (32'h1 << b);
      cyc(0, 0, 0, 0);
      check("R2 unmasked bit differs", brk_req, 0);
    end
    wr(4'd2, 32'h103);
    bus_vaddr = 32'h1234_5678; bus_iaddr = 32'h0;
    cyc(0, 0, 0, 0);
    check("R3 internal bus selected, miss", brk_req, 0);
    bus_iaddr = 32'h1234_56FF; bus_vaddr = 32'h0;
    cyc(0, 0, 0, 0);
    check("R3 internal bus selected, hit", brk_req, 1);

    // R12 post flag
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd2, 32'h401);
    cyc(1, 0, 0, 0);
    check("R12 fetch after", brk_post, 1);
    wr(4'd2, 32'h001);
    cyc(1, 0, 0, 0);
    check("R12 fetch before", brk_post, 0);
    check("R12 fetch before req", brk_req, 1);
    wr(4'd2, 32'h403);
    cyc(0, 0, 0, 0);
    check("R12 data match not post", brk_post, 0);
    check("R12 data match req", brk_req, 1);
    wr(4'd2, 32'h0);
    wr(4'd15, 32'h0);

    // R8 channel B data compare
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd11, 32'hA5A5_0F0F);
    wr(4'd12, 32'h0);
    wr(4'd10, 32'h3);
    bus_vdata = 32'hA5A5_0F0F; bus_idata = 32'h0;
    cyc(0, 1, 0, 2);
    check("R8 data equal", brk_req, 1);
    check("R8 hit_b", hit_b, 1);
    check("R8 hit_a untouched", hit_a, 0);
    for (int b = 0; b < 32; b++) begin
      bus_vdata = 32'hA5A5_0F0F ^ (32'h1 << b);
      wr(4'd12, 32'h0);
      cyc(0, 1, 0, 2);
      check("R8 data bit differs", brk_req, 0);
      wr(4'd12, 32'h1 << b);
      cyc(0, 1, 0, 2);
      check("R8 differing bit masked", brk_req, 1);
    end
    wr(4'd12, 32'h0);
    wr(4'd10, 32'h203);
    bus_vdata = 32'hA5A5_0F0F; bus_idata = 32'h0;
    cyc(0, 1, 0, 2);
    check("R8 internal data bus miss", brk_req, 0);
    bus_idata = 32'hA5A5_0F0F; bus_vdata = 32'h0;
    cyc(0, 1, 0, 2);
    check("R8 internal data bus hit", brk_req, 1);

    // R9 repeat counter
    for (int n = 1; n < 6; n++) begin
      wr(4'd13, 32'(n));
      for (int i = 1; i <= n + 2; i++) begin
        cyc(0, 1, 0, 2);
        check("R9 repeat count", brk_req, (i >= n) ? 1 : 0);
      end
    end
    wr(4'd13, 32'd3);
    cyc(0, 1, 0, 1);
    cyc(0, 1, 0, 1);
    wr(4'd13, 32'd2);
    cyc(0, 1, 0, 1);
    check("R9 reload restarts", brk_req, 0);
    cyc(0, 1, 0, 1);
    check("R9 reload fires", brk_req, 1);
    // match during count write is ignored
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd13; cfg_wdata = 32'd1; bus_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0;
    check("R9 match during write ignored", brk_req, 0);
    cyc(0, 1, 0, 1);
    check("R9 count one fires", brk_req, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule